// File: doc/BRIEF.md
# Accumulator and MQ Double-Length Shifter

This block holds a 38-bit accumulator and a 36-bit multiplier-quotient register (MQ) and shifts them under the control of a 3-bit operation code. It provides six shift operations. Two act on the accumulator alone. Two are arithmetic shifts across the accumulator and MQ as one double-length value. Two are logical shifts across both registers. In the accumulator, bit 37 is the sign, bit 36 is Q, bit 35 is P, and bits 34:0 are the magnitude. In MQ, bit 35 is the sign and bits 34:0 are the magnitude.

The arithmetic shifts never move a sign bit. A sign either stays where it is or is copied from one register to the other. A sticky overflow flag records any one bit that reaches the P position. Shift counts that run past the width of the registers saturate to zero.

The shift count comes from the low 8 bits of an address field, and the upper bits of that field are ignored. A load port presets both registers. By default the unit completes a shift in a single cycle. A parameter selects a serial variant instead, which moves one position per cycle and reports completion with the same done pulse.

Top module: `acc_mq_shifter`

## Requirements
- R1: After reset, `acc`, `mq`, `ovf`, `busy` and `done` are all zero.
- R2: When idle, a cycle with `ld_en` high and `start` low loads `ld_acc` and `ld_mq` at that clock edge. When `start` and `ld_en` are high in the same cycle, the load is dropped and the shift uses the previous register contents. The register layout is as follows. In `acc`, bit 37 is the sign, bit 36 is Q, bit 35 is P and bits 34:0 are the magnitude. In `mq`, bit 35 is the sign and bits 34:0 are the magnitude.
- R3: Op code 0 (accumulator left) keeps the accumulator sign and shifts acc[36:0] left by the count. A count of 37 or more gives zero. `ovf` is set if any one bit of acc[34:0] reaches bit 35 or above; for counts of 35 or more, this means any nonzero acc[34:0]. MQ is unchanged.
- R4: Op code 1 (accumulator right) keeps the accumulator sign and shifts acc[36:0] right by the count. A count of 37 or more gives zero. MQ is unchanged and `ovf` is untouched.
- R5: Op code 2 (long arithmetic left) repeats the following once per count. The 72-bit value {acc[36:0], mq[34:0]} moves left by one with a zero entering at the bottom, so mq[34] enters acc[0]. MQ's sign stays fixed. `ovf` is set whenever acc[35] becomes 1. At the end, the accumulator sign takes the MQ sign.
- R6: Op code 3 (long arithmetic right) shifts {acc[36:0], mq[34:0]} right by the count with zeros entering at the top. At a count of 72 or more, both magnitudes are zero. The accumulator sign is kept and is copied into mq[35].
- R7: Op code 4 (logical left) repeats the following once per count. {acc[36:0], mq[35:0]} moves left by one, so the MQ sign bit enters acc[0]. The accumulator sign is kept. `ovf` is set whenever acc[35] becomes 1.
- R8: Op code 5 (logical right) shifts {acc[36:0], mq[35:0]} right by the count with zeros entering at the top, keeping the accumulator sign. At a count of 36, MQ holds acc[35:0] and the accumulator keeps only its old Q bit. At a count of 73 or more, both magnitudes are zero.
- R9: The count is `addr[7:0]`, and `addr[14:8]` has no effect. A count of zero leaves both magnitudes unchanged, but the sign copies of R5 and R6 still take place.
- R10: `ovf` stays set until reset or until a cycle with `ovf_clr` high. If a shift sets overflow in the same cycle that `ovf_clr` is high, `ovf` ends up 1.
- R11: Op codes 6 and 7 change neither register nor `ovf`, but still produce a done pulse.
- R12: In the default single-cycle configuration, results and a one-cycle `done` pulse appear at the clock edge that samples `start`, and `busy` stays low. `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load both registers when idle |
| ld_acc | input | 38 | Accumulator load value |
| ld_mq | input | 36 | MQ load value |
| start | input | 1 | Begin the selected shift |
| op | input | 3 | Shift operation code |
| addr | input | 15 | Address field; low 8 bits are the count |
| ovf_clr | input | 1 | Clear the overflow flag |
| acc | output | 38 | Accumulator contents |
| mq | output | 36 | MQ contents |
| ovf | output | 1 | Sticky overflow flag |
| busy | output | 1 | Serial shift in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Clearing the overflow flag and setting it by a shift can land in the same cycle. The bench provokes this by raising `ovf_clr` together with `start` for an accumulator left shift that pushes a one into P, and expects `ovf` to read 1. It then repeats the pairing with a right shift, which cannot overflow, and expects `ovf` to read 0. Both cases are judged against a bit-by-bit reference model, whose expected values pass through a scoreboard queue.

// File: rtl/acc_shf_pkg.sv
package acc_shf_pkg;

    localparam int unsigned DEF_MAG_W = 35;

    typedef enum logic [2:0] {
        SH_ACC_L  = 3'd0,
        SH_ACC_R  = 3'd1,
        SH_LONG_L = 3'd2,
        SH_LONG_R = 3'd3,
        SH_LOG_L  = 3'd4,
        SH_LOG_R  = 3'd5,
        SH_NONE6  = 3'd6,
        SH_NONE7  = 3'd7
    } shf_op_e;

    // How the two registers are laid into the shift frame
    typedef enum logic [1:0] {
        FR_ACC_ONLY,
        FR_LONG,
        FR_LOGIC,
        FR_NONE
    } frame_kind_e;

    function automatic frame_kind_e shf_kind(input shf_op_e op);
        case (op)
            SH_ACC_L, SH_ACC_R:   return FR_ACC_ONLY;
            SH_LONG_L, SH_LONG_R: return FR_LONG;
            SH_LOG_L, SH_LOG_R:   return FR_LOGIC;
            default:              return FR_NONE;
        endcase
    endfunction

    function automatic logic shf_is_left(input shf_op_e op);
        return (op == SH_ACC_L) || (op == SH_LONG_L) || (op == SH_LOG_L);
    endfunction

endpackage

// File: rtl/acc_shf_pack.sv
// Builds the shift frame: accumulator Q,P,magnitude on top, MQ part below.
module acc_shf_pack
    import acc_shf_pkg::*;
#(
    parameter int unsigned MAG_W = DEF_MAG_W
) (
    input  shf_op_e                  op,
    input  logic [MAG_W+1:0]         acc_mag,
    input  logic [MAG_W:0]           mq,
    output logic [2*MAG_W+2:0]       frame
);
    localparam int unsigned MQ_W = MAG_W + 1;

    always_comb begin
        case (shf_kind(op))
            FR_ACC_ONLY: frame = {acc_mag, {MQ_W{1'b0}}};
            FR_LONG:     frame = {acc_mag, mq[MAG_W-1:0], 1'b0};
            FR_LOGIC:    frame = {acc_mag, mq};
            default:     frame = '0;
        endcase
    end
endmodule

// File: rtl/acc_shf_barrel.sv
// Shifts the frame and reports whether a one passed through the P slot.
module acc_shf_barrel #(
    parameter int unsigned FRAME_W = 73,
    parameter int unsigned CNT_W   = 8
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [CNT_W-1:0]   amt,
    input  logic               left,
    output logic [FRAME_W-1:0] frame_o,
    output logic               ovf
);
    localparam int unsigned P_IDX = FRAME_W - 2;

    int unsigned          s_eff;
    logic [P_IDX-1:0]     window;

    always_comb begin
        if (left) begin
            frame_o = frame_i << amt;
        end else begin
            frame_o = frame_i >> amt;
        end
        s_eff  = (32'(amt) > P_IDX) ? P_IDX : 32'(amt);
        // bits below P that travel through P within s_eff steps
        window = frame_i[P_IDX-1:0] >> (P_IDX - s_eff);
        ovf    = left && (window != '0);
    end
endmodule

// File: rtl/acc_shf_unpack.sv
// Writes a shifted frame back into accumulator and MQ with the sign rules.
module acc_shf_unpack
    import acc_shf_pkg::*;
#(
    parameter int unsigned MAG_W = DEF_MAG_W
) (
    input  shf_op_e              op,
    input  logic [2*MAG_W+2:0]   frame,
    input  logic [MAG_W+2:0]     acc_old,
    input  logic [MAG_W:0]       mq_old,
    output logic [MAG_W+2:0]     acc_new,
    output logic [MAG_W:0]       mq_new
);
    localparam int unsigned ACC_W   = MAG_W + 3;
    localparam int unsigned MQ_W    = MAG_W + 1;
    localparam int unsigned AMAG_W  = MAG_W + 2;
    localparam int unsigned FRAME_W = AMAG_W + MQ_W;

    logic [AMAG_W-1:0] fmag;
    logic              sgn;

    always_comb begin
        fmag    = frame[FRAME_W-1 -: AMAG_W];
        sgn     = acc_old[ACC_W-1];
        acc_new = acc_old;
        mq_new  = mq_old;
        case (shf_kind(op))
            FR_ACC_ONLY: begin
                acc_new = {sgn, fmag};
            end
            FR_LONG: begin
                if (shf_is_left(op)) begin
                    sgn = mq_old[MQ_W-1];
                end
                acc_new = {sgn, fmag};
                mq_new  = {sgn, frame[MQ_W-1:1]};
            end
            FR_LOGIC: begin
                acc_new = {sgn, fmag};
                mq_new  = frame[MQ_W-1:0];
            end
            default: begin
                acc_new = acc_old;
                mq_new  = mq_old;
            end
        endcase
    end
endmodule

// File: rtl/acc_mq_shifter.sv
module acc_mq_shifter
    import acc_shf_pkg::*;
#(
    parameter int unsigned MAG_W  = DEF_MAG_W,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned SERIAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [MAG_W+2:0]  ld_acc,
    input  logic [MAG_W:0]    ld_mq,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ovf_clr,
    output logic [MAG_W+2:0]  acc,
    output logic [MAG_W:0]    mq,
    output logic              ovf,
    output logic              busy,
    output logic              done
);
    localparam int unsigned ACC_W   = MAG_W + 3;
    localparam int unsigned MQ_W    = MAG_W + 1;
    localparam int unsigned AMAG_W  = MAG_W + 2;
    localparam int unsigned FRAME_W = AMAG_W + MQ_W;

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [MQ_W-1:0]    mq;
        logic               ovf;
        logic               busy;
        logic               done;
        shf_op_e            op;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] frame;
    } state_t;

    state_t st_d, st_q;

    shf_op_e            op_in;
    logic [CNT_W-1:0]   cnt_req;
    logic [CNT_W-1:0]   cnt_clamp;
    logic [FRAME_W-1:0] pk_frame;
    logic [FRAME_W-1:0] bar_in;
    logic [FRAME_W-1:0] bar_out;
    logic [CNT_W-1:0]   bar_amt;
    shf_op_e            bar_op;
    logic               bar_ovf;
    logic [FRAME_W-1:0] unp_frame;
    shf_op_e            unp_op;
    logic [ACC_W-1:0]   unp_acc;
    logic [MQ_W-1:0]    unp_mq;
    logic               ovf_set;

    assign op_in     = shf_op_e'(op);
    assign cnt_req   = addr[CNT_W-1:0];
    // beyond the frame width every result is zero, so serial work stops there
    assign cnt_clamp = (32'(cnt_req) > FRAME_W) ? CNT_W'(FRAME_W) : cnt_req;

    acc_shf_pack #(.MAG_W(MAG_W)) u_pack (
        .op      (op_in),
        .acc_mag (st_q.acc[AMAG_W-1:0]),
        .mq      (st_q.mq),
        .frame   (pk_frame)
    );

    generate
        if (SERIAL != 0) begin : g_serial
            assign bar_in    = st_q.frame;
            assign bar_amt   = CNT_W'(1);
            assign bar_op    = st_q.op;
            assign unp_frame = st_q.frame;
            assign unp_op    = st_q.op;
        end else begin : g_single
            assign bar_in    = pk_frame;
            assign bar_amt   = cnt_req;
            assign bar_op    = op_in;
            assign unp_frame = bar_out;
            assign unp_op    = op_in;
        end
    endgenerate

    acc_shf_barrel #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_barrel (
        .frame_i (bar_in),
        .amt     (bar_amt),
        .left    (shf_is_left(bar_op)),
        .frame_o (bar_out),
        .ovf     (bar_ovf)
    );

    acc_shf_unpack #(.MAG_W(MAG_W)) u_unpack (
        .op      (unp_op),
        .frame   (unp_frame),
        .acc_old (st_q.acc),
        .mq_old  (st_q.mq),
        .acc_new (unp_acc),
        .mq_new  (unp_mq)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        ovf_set   = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt != '0) begin
                st_d.frame = bar_out;
                st_d.cnt   = st_q.cnt - CNT_W'(1);
                ovf_set    = bar_ovf;
            end else begin
                st_d.acc  = unp_acc;
                st_d.mq   = unp_mq;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start) begin
            if (SERIAL != 0) begin
                st_d.busy  = 1'b1;
                st_d.frame = pk_frame;
                st_d.cnt   = cnt_clamp;
                st_d.op    = op_in;
            end else begin
                st_d.acc  = unp_acc;
                st_d.mq   = unp_mq;
                st_d.done = 1'b1;
                ovf_set   = bar_ovf;
            end
        end else if (ld_en) begin
            st_d.acc = ld_acc;
            st_d.mq  = ld_mq;
        end
        // a new overflow outranks a clear in the same cycle
        st_d.ovf = (st_q.ovf & ~ovf_clr) | ovf_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc  = st_q.acc;
    assign mq   = st_q.mq;
    assign ovf  = st_q.ovf;
    assign busy = st_q.busy;
    assign done = st_q.done;

endmodule

// File: rtl/acc_mq_shifter_chk.sv
module acc_mq_shifter_chk #(
    parameter int unsigned MAG_W = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_en,
    input logic [MAG_W+2:0] ld_acc,
    input logic             start,
    input logic             ovf_clr,
    input logic [MAG_W+2:0] acc,
    input logic [MAG_W:0]   mq,
    input logic             ovf,
    input logic             busy,
    input logic             done
);
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !start && !busy) |=> (acc == $past(ld_acc))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !start && !busy) |=> ($stable(acc) && $stable(mq))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R10

    AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !start && !busy) |=> !ovf); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R12

    AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(start) || $past(busy))); // R12
endmodule

bind acc_mq_shifter acc_mq_shifter_chk #(.MAG_W(MAG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_acc  (ld_acc),
    .start   (start),
    .ovf_clr (ovf_clr),
    .acc     (acc),
    .mq      (mq),
    .ovf     (ovf),
    .busy    (busy),
    .done    (done)
);

// File: tb/acc_mq_shifter_tb.sv
module acc_mq_shifter_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [37:0] ld_acc = '0;
    logic [35:0] ld_mq = '0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [14:0] addr = '0;
    logic        ovf_clr = 1'b0;
    logic [37:0] acc;
    logic [35:0] mq;
    logic        ovf;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [37:0] acc;
        logic [35:0] mq;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;

    logic [37:0] m_acc = '0;
    logic [35:0] m_mq  = '0;
    logic        m_ovf = 1'b0;

    acc_mq_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc), .ld_mq(ld_mq),
        .start(start), .op(op), .addr(addr), .ovf_clr(ovf_clr),
        .acc(acc), .mq(mq), .ovf(ovf), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    // Reference model, step by step from the requirements
    task automatic model(input logic [2:0] o, input int c);
        logic [36:0] a = m_acc[36:0];
        logic [35:0] q = m_mq;
        logic        s = m_acc[37];
        logic        v = 1'b0;
        case (o)
            3'd0: begin
                if (c >= 35) v = (a[34:0] != 0);
                else v = ((a[34:0] >> (35 - c)) != 0);
                a = (c >= 37) ? 37'd0 : (a << c);
            end
            3'd1: a = (c >= 37) ? 37'd0 : (a >> c);
            3'd2: begin
                for (int i = 0; i < c; i++) begin
                    a = {a[35:0], q[34]};
                    q[34:0] = {q[33:0], 1'b0};
                    if (a[35]) v = 1'b1;
                end
                s = q[35];
            end
            3'd3: begin
                for (int i = 0; i < c; i++) begin
                    q[34:0] = {a[0], q[34:1]};
                    a = a >> 1;
                end
                q[35] = s;
            end
            3'd4: begin
                for (int i = 0; i < c; i++) begin
                    a = {a[35:0], q[35]};
                    q = {q[34:0], 1'b0};
                    if (a[35]) v = 1'b1;
                end
            end
            3'd5: begin
                for (int i = 0; i < c; i++) begin
                    q = {a[0], q[35:1]};
                    a = a >> 1;
                end
            end
            default: ;
        endcase
        m_acc = {s, a};
        m_mq  = q;
        m_ovf = m_ovf | v;
    endtask

    task automatic check1(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [37:0] a, input logic [35:0] q);
        @(negedge clk);
        ld_en = 1'b1; ld_acc = a; ld_mq = q;
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
        m_acc = a; m_mq = q;
        check1(acc == a && mq == q, "R2 load", {acc, mq[25:0]}, {a, q[25:0]});
    endtask

    task automatic clear_ovf();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ovf_clr = 1'b0;
        m_ovf = 1'b0;
        check1(ovf == 1'b0, "R10 clear", 64'(ovf), 64'd0);
    endtask

    // Driver: predicts, queues the expectation, then issues the shift
    task automatic run_op(input logic [2:0] o, input logic [14:0] a, input logic clr,
                          input logic with_ld, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; addr = a; start = 1'b1; ovf_clr = clr; ld_en = with_ld;
        ld_acc = ~m_acc; ld_mq = ~m_mq;
        if (clr) m_ovf = 1'b0;
        model(o, int'(a[7:0]));
        e.acc = m_acc; e.mq = m_mq; e.ovf = m_ovf; e.tag = tag;
        sbq.push_back(e);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; ovf_clr = 1'b0; ld_en = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // Monitor: compares each completion against the queue head
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_checks++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected done: actual=1 expected=0");
            end else begin
                mon_e = sbq.pop_front();
                if (acc !== mon_e.acc || mq !== mon_e.mq || ovf !== mon_e.ovf) begin
                    n_fail++;
                    $display("FAIL %s: actual acc=%h mq=%h ovf=%b expected acc=%h mq=%h ovf=%b",
                             mon_e.tag, acc, mq, ovf, mon_e.acc, mon_e.mq, mon_e.ovf);
                end
            end
        end
    end

    int lrs_cnt[8] = '{1, 34, 35, 36, 37, 71, 72, 200};
    int lgr_cnt[6] = '{1, 35, 36, 37, 72, 73};
    int lgl_cnt[3] = '{1, 36, 50};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1(acc == 0 && mq == 0 && !ovf && !busy && !done, "R1 reset",
               {acc, mq[25:0]}, 64'd0);

        // R3 accumulator left
        load(38'h20_0000_0001, 36'h8_0000_0003);
        run_op(3'd0, 15'd3, 1'b0, 1'b0, "R3 small count");
        load(38'h20_0000_0001, 36'h0_0000_0000);
        run_op(3'd0, 15'd34, 1'b0, 1'b0, "R3 bit reaches 34, no ovf");
        run_op(3'd0, 15'd1, 1'b0, 1'b0, "R3 bit enters P, ovf");
        clear_ovf();
        load(38'h00_0000_0005, 36'h0_0000_0000);
        run_op(3'd0, 15'd37, 1'b0, 1'b0, "R3 count 37 clears");

        // R10 same-cycle clear and set
        load(38'h00_0000_0001, 36'h0_0000_0000);
        run_op(3'd0, 15'd36, 1'b1, 1'b0, "R10 set beats clear");
        run_op(3'd1, 15'd0, 1'b1, 1'b0, "R10 clear with right shift");

        // R4 accumulator right
        load(38'h3F_0000_00F0, 36'h5_5555_5555);
        run_op(3'd1, 15'd5, 1'b0, 1'b0, "R4 count 5");
        run_op(3'd1, 15'd30, 1'b0, 1'b0, "R4 count 30");
        load(38'h3F_0000_00F0, 36'h5_5555_5555);
        run_op(3'd1, 15'd36, 1'b0, 1'b0, "R4 count 36 keeps Q");
        load(38'h3F_0000_00F0, 36'h5_5555_5555);
        run_op(3'd1, 15'd37, 1'b0, 1'b0, "R4 count 37 clears");

        // R5 long left
        load(38'h10_0000_0000, 36'hC_0000_0001);
        run_op(3'd2, 15'd1, 1'b0, 1'b0, "R5 one step, sign copy");
        load(38'h00_0000_0001, 36'h0_0000_0000);
        run_op(3'd2, 15'd35, 1'b0, 1'b0, "R5 reach P ovf");
        run_op(3'd2, 15'd40, 1'b0, 1'b0, "R5 further");
        clear_ovf();
        load(38'h20_0000_0007, 36'h0_1234_5678);
        run_op(3'd2, 15'd0, 1'b0, 1'b0, "R9 count 0 long left sign copy");

        // R6 long right
        foreach (lrs_cnt[k]) begin
            load(38'h2F_FFFF_FFFF, 36'h0_1234_5678);
            run_op(3'd3, 15'(lrs_cnt[k]), 1'b0, 1'b0, "R6 long right");
        end
        load(38'h20_0000_0003, 36'h0_0000_0009);
        run_op(3'd3, 15'd0, 1'b0, 1'b0, "R9 count 0 long right sign copy");

        // R7 logical left
        foreach (lgl_cnt[k]) begin
            load(38'h21_2345_6789, 36'hA_BCDE_F012);
            run_op(3'd4, 15'(lgl_cnt[k]), 1'b0, 1'b0, "R7 logical left");
        end
        clear_ovf();

        // R8 logical right
        foreach (lgr_cnt[k]) begin
            load(38'h3E_DCBA_9876, 36'hF_0F0F_0F0F);
            run_op(3'd5, 15'(lgr_cnt[k]), 1'b0, 1'b0, "R8 logical right");
        end

        // R9 upper address bits ignored
        load(38'h1F_0000_FFFF, 36'h0_0000_0001);
        run_op(3'd1, 15'h7F05, 1'b0, 1'b0, "R9 upper addr bits");

        // R11 reserved codes
        run_op(3'd6, 15'd3, 1'b0, 1'b0, "R11 code 6");
        run_op(3'd7, 15'd9, 1'b0, 1'b0, "R11 code 7");

        // R2 load dropped when start shares the cycle
        run_op(3'd1, 15'd2, 1'b0, 1'b1, "R2 start beats load");

        // R12 done is a single pulse and busy stays low
        @(negedge clk);
        check1(!done && !busy, "R12 done one cycle", {62'd0, done, busy}, 64'd0);

        for (int k = 0; k < 60; k++) begin
            load(38'({$urandom, $urandom}), 36'({$urandom, $urandom}));
            run_op(3'($urandom % 6), 15'($urandom % 80), 1'($urandom % 2), 1'b0,
                   "R3 R4 R5 R6 R7 R8 mixed");
        end

        repeat (5) @(negedge clk);
        if (sbq.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 pending results: actual=%0d expected=0", sbq.size());
        end
        summary();
        $finish;
    end
endmodule